// File: doc/BRIEF.md
# Pixel Word Serializer with Framing Clock Lane

The block turns one 28-bit pixel word per pixel-clock period into five serial streams running at seven times the pixel rate. Four data lanes each send a seven-bit slice of the word. A fifth lane sends a fixed seven-bit marker, so a receiver can find where each word begins. The word holds 24 colour bits (8 each for red, green and blue), horizontal sync, vertical sync, data enable and one spare bit. The mapping from word to lanes does not depend on what each bit means.

A static select input sets the pixel-clock edge on which the word is taken. High selects the rising edge. Low selects the falling edge, which is also what a board-level pull-down gives when the pin is left open. The 7x bit clock comes from outside and is phase-locked to the pixel clock, with pixel-clock edges placed away from bit-clock rising edges. Each captured word waits in a shadow register. It moves into the lane shifters only at the next frame boundary, which is found by sampling the pixel clock with the bit clock. An active-low power-down input floats all five outputs.

Top module: `pix_serializer`

## Requirements
- R1: While reset is asserted and power-down is not asserted, all four data lanes and the framing lane drive 0.
- R2: Data lane L (L = 0..3) carries word bits 7L+6 down to 7L. The bits go out most significant first, one per bit-clock period, and each frame is exactly seven bit periods long.
- R3: Every frame, the framing lane sends the pattern 1,1,0,0,0,1,1 in sending order. Its first bit goes out in the same bit period as the first bit of each data lane.
- R4: With the select input high, the word sent is the value present at the pixel-clock rising edge.
- R5: With the select input low (including an open pin pulled low), the word sent is the value present at the pixel-clock falling edge.
- R6: Consider the pixel-clock rising edge that ends the period in which a word was captured. The first bit of that word appears on the lanes at the second bit-clock rising edge after that pixel-clock edge.
- R7: While power-down is asserted (low), all five outputs are high-impedance. Shifting goes on underneath, so on release the stream carries on at the bit it would have reached anyway.
- R8: Input changes during a frame do not disturb the frame being sent. Each captured word is sent exactly once, whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk_i | input | 1 | Serial bit clock, 7x the pixel rate, phase-locked to it |
| pix_clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwrdn_ni | input | 1 | Power-down, active low; floats the outputs |
| rise_sel_i | input | 1 | Capture edge select: 1 rising, 0 falling |
| pix_word_i | input | 28 | Pixel word: colour bits, syncs, enable, spare |
| lane_o | output | 4 | Serial data lanes |
| clk_lane_o | output | 1 | Serial framing-pattern lane |

## Verification
The bench changes the input word twice per pixel period: once between the rising and falling pixel-clock edges, and once after the falling edge. A design that used the wrong capture edge, or ignored the select input, therefore sends the wrong word of each pair. Both changes land while a frame is still shifting. A design that loaded its shifters straight from the input, or loaded them at the wrong phase, would show bit slips or mixed words. Power-down windows open and close mid-frame. The bench expects high-impedance during each window and the correct bit position right after it, which catches a design that freezes or restarts its shifters.

// File: rtl/pixser_pkg.sv
package pixser_pkg;
   localparam int unsigned SLOT_BITS  = 7;
   localparam int unsigned LANE_CNT   = 4;
   localparam int unsigned WORD_W     = SLOT_BITS * LANE_CNT;
   localparam int unsigned SYNC_STAGES = 1;
   localparam logic [SLOT_BITS-1:0] FRAME_MARK = 7'b1100011;
   typedef logic [WORD_W-1:0] pix_word_t;
endpackage

// File: rtl/pixser_capture.sv
module pixser_capture #(
   parameter int unsigned WORD_W = 28
) (
   input  logic              pix_clk_i,
   input  logic              rst_ni,
   input  logic              rise_sel_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [WORD_W-1:0] shadow_o
);
   logic [WORD_W-1:0] rise_q;
   logic [WORD_W-1:0] fall_q;

   always_ff @(posedge pix_clk_i or negedge rst_ni) begin
      if (!rst_ni) rise_q <= '0;
      else         rise_q <= word_i;
   end

   always_ff @(negedge pix_clk_i or negedge rst_ni) begin
      if (!rst_ni) fall_q <= '0;
      else         fall_q <= word_i;
   end

   assign shadow_o = rise_sel_i ? rise_q : fall_q;
endmodule

// File: rtl/pixser_framer.sv
module pixser_framer #(
   parameter int unsigned SYNC_STAGES = 1
) (
   input  logic bit_clk_i,
   input  logic rst_ni,
   input  logic pix_clk_i,
   output logic load_o
);
   localparam int unsigned HIST_W = SYNC_STAGES + 1;

   logic [HIST_W-1:0] hist_q;

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   always_ff @(posedge bit_clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q <= '0;
      else         hist_q <= {hist_q[HIST_W-2:0], pix_clk_i};
   end

   assign load_o = hist_q[HIST_W-2] & ~hist_q[HIST_W-1];
endmodule

// File: rtl/pixser_lane.sv
module pixser_lane #(
   parameter int unsigned SLOT_BITS = 7
) (
   input  logic                 bit_clk_i,
   input  logic                 rst_ni,
   input  logic                 load_i,
   input  logic [SLOT_BITS-1:0] slot_i,
   output logic                 ser_o
);
   logic [SLOT_BITS-1:0] sr_q;

   if (SLOT_BITS < 2) begin : g_bad_slot
      $error("SLOT_BITS must be at least 2");
   end

   always_ff @(posedge bit_clk_i or negedge rst_ni) begin
      if (!rst_ni)     sr_q <= '0;
      else if (load_i) sr_q <= slot_i;
      else             sr_q <= {sr_q[SLOT_BITS-2:0], 1'b0};
   end

   assign ser_o = sr_q[SLOT_BITS-1];
endmodule

// File: rtl/pix_serializer.sv
module pix_serializer #(
   parameter int unsigned SLOT_BITS   = pixser_pkg::SLOT_BITS,
   parameter int unsigned LANE_CNT    = pixser_pkg::LANE_CNT,
   parameter int unsigned SYNC_STAGES = pixser_pkg::SYNC_STAGES,
   parameter logic [SLOT_BITS-1:0] FRAME_MARK = pixser_pkg::FRAME_MARK
) (
   input  logic                        bit_clk_i,
   input  logic                        pix_clk_i,
   input  logic                        rst_ni,
   input  logic                        pwrdn_ni,
   input  logic                        rise_sel_i,
   input  logic [SLOT_BITS*LANE_CNT-1:0] pix_word_i,
   output logic [LANE_CNT-1:0]         lane_o,
   output logic                        clk_lane_o
);
   localparam int unsigned WORD_W = SLOT_BITS * LANE_CNT;

   if (LANE_CNT < 1) begin : g_bad_lanes
      $error("LANE_CNT must be at least 1");
   end

   logic [WORD_W-1:0]   shadow_word;
   logic                frame_load;
   logic [LANE_CNT-1:0] lane_bits;
   logic                mark_bit;

   pixser_capture #(.WORD_W(WORD_W)) u_capture (
      .pix_clk_i (pix_clk_i),
      .rst_ni    (rst_ni),
      .rise_sel_i(rise_sel_i),
      .word_i    (pix_word_i),
      .shadow_o  (shadow_word)
   );

   pixser_framer #(.SYNC_STAGES(SYNC_STAGES)) u_framer (
      .bit_clk_i(bit_clk_i),
      .rst_ni   (rst_ni),
      .pix_clk_i(pix_clk_i),
      .load_o   (frame_load)
   );

   for (genvar l = 0; l < LANE_CNT; l++) begin : g_lane
      pixser_lane #(.SLOT_BITS(SLOT_BITS)) u_lane (
         .bit_clk_i(bit_clk_i),
         .rst_ni   (rst_ni),
         .load_i   (frame_load),
         .slot_i   (shadow_word[l*SLOT_BITS +: SLOT_BITS]),
         .ser_o    (lane_bits[l])
      );
   end

   pixser_lane #(.SLOT_BITS(SLOT_BITS)) u_mark_lane (
      .bit_clk_i(bit_clk_i),
      .rst_ni   (rst_ni),
      .load_i   (frame_load),
      .slot_i   (FRAME_MARK),
      .ser_o    (mark_bit)
   );

   assign lane_o     = pwrdn_ni ? lane_bits : {LANE_CNT{1'bz}};
   assign clk_lane_o = pwrdn_ni ? mark_bit  : 1'bz;
endmodule

// File: rtl/pixser_chk.sv
module pixser_chk #(
   parameter int unsigned SLOT_BITS = 7,
   parameter int unsigned LANE_CNT  = 4,
   parameter logic [SLOT_BITS-1:0] FRAME_MARK = 7'b1100011
) (
   input logic                          bit_clk_i,
   input logic                          rst_ni,
   input logic                          pwrdn_ni,
   input logic                          frame_load_i,
   input logic [SLOT_BITS*LANE_CNT-1:0] word_i,
   input logic [LANE_CNT-1:0]           lane_o,
   input logic                          clk_lane_o
);
   localparam int unsigned CNT_W = $clog2(SLOT_BITS) + 1;

   logic [CNT_W-1:0] since_load;
   logic             seen_load;

   always_ff @(posedge bit_clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         since_load <= '0;
         seen_load  <= 1'b0;
      end else if (frame_load_i) begin
         since_load <= '0;
         seen_load  <= 1'b1;
      end else if (since_load != {CNT_W{1'b1}}) begin
         since_load <= since_load + 1'b1;
      end
   end

   // R2
   frame_len_chk: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
      (frame_load_i && seen_load) |-> (since_load == CNT_W'(SLOT_BITS - 1)));

   // R3
   mark_head_chk: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
      (frame_load_i && pwrdn_ni) |=> (!pwrdn_ni || clk_lane_o == FRAME_MARK[SLOT_BITS-1]));

   // R3
   mark_third_chk: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
      frame_load_i |=> ##2 (!pwrdn_ni || clk_lane_o == FRAME_MARK[SLOT_BITS-3]));

   // R7
   drive_known_chk: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
      pwrdn_ni |-> !$isunknown({lane_o, clk_lane_o}));

   for (genvar l = 0; l < LANE_CNT; l++) begin : g_lane_chk
      // R2
      lane_msb_chk: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
         (frame_load_i && pwrdn_ni) |=>
         (!pwrdn_ni || lane_o[l] == $past(word_i[l*SLOT_BITS + SLOT_BITS - 1])));
   end
endmodule

bind pix_serializer pixser_chk #(
   .SLOT_BITS (SLOT_BITS),
   .LANE_CNT  (LANE_CNT),
   .FRAME_MARK(FRAME_MARK)
) u_chk (
   .bit_clk_i   (bit_clk_i),
   .rst_ni      (rst_ni),
   .pwrdn_ni    (pwrdn_ni),
   .frame_load_i(frame_load),
   .word_i      (shadow_word),
   .lane_o      (lane_o),
   .clk_lane_o  (clk_lane_o)
);

// File: tb/test_pix_serializer.sv
module test_pix_serializer;
   localparam int BIT_PERIOD = 10;
   localparam int SB  = 7;
   localparam int NL  = 4;
   localparam int WW  = SB * NL;
   localparam int NPER = 48;
   localparam logic [SB-1:0] MARK = 7'b1100011;

   logic          bclk = 1'b0;
   logic          pclk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pd_n = 1'b1;
   logic          sel = 1'b0;
   logic [WW-1:0] pix = '0;
   wire  [NL-1:0] lane;
   wire           clk_lane;

   logic [WW-1:0] a_q [NPER];
   logic [WW-1:0] b_q [NPER];
   logic          sel_q [NPER];
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   pix_serializer i_pix_serializer (
      .bit_clk_i (bclk),
      .pix_clk_i (pclk),
      .rst_ni    (rst_n),
      .pwrdn_ni  (pd_n),
      .rise_sel_i(sel),
      .pix_word_i(pix),
      .lane_o    (lane),
      .clk_lane_o(clk_lane)
   );

   always #(BIT_PERIOD/2) bclk = ~bclk;

   task automatic check_bit(string req, int smp, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s sample %0d: actual %b expected %b", req, smp, act, exp);
      end
   endtask

   function automatic logic [WW-1:0] gen(int k, bit second);
      logic [WW-1:0] v;
      case (k % 6)
         0: v = second ? '0 : '1;
         1: v = second ? '1 : '0;
         2: v = second ? ~(WW'(1) << (k % WW)) : (WW'(1) << (k % WW));
         3: v = second ? {WW/2{2'b10}} : {WW/2{2'b01}};
         default: v = WW'($urandom());
      endcase
      return v;
   endfunction

   // expected stream: word of period k starts at sample 7(k+1)+2 (R6)
   task automatic sample(int n);
      int j, kk, b;
      logic [WW-1:0] w;
      string req;
      if (n < 9) return;
      j  = n - 9;
      kk = j / SB;
      b  = SB - 1 - (j % SB);
      w  = sel_q[kk] ? b_q[kk] : a_q[kk];
      for (int l = 0; l < NL; l++) begin
         if (!pd_n) req = "R7";
         else if (sel_q[kk]) req = "R2 R4 R6 R8";
         else req = "R2 R5 R6 R8";
         check_bit(req, n, lane[l], pd_n ? w[l*SB + b] : 1'bz);
      end
      check_bit(pd_n ? "R3" : "R7", n, clk_lane, pd_n ? MARK[b] : 1'bz);
   endtask

   task automatic drive(int k, int s);
      if (s == 0) pclk = 1'b1;
      if (s == 4) pclk = 1'b0;
      if (s == 2) begin a_q[k] = gen(k, 1'b0); pix = a_q[k]; end
      if (s == 5) begin b_q[k] = gen(k, 1'b1); pix = b_q[k]; end
      if (s == 3) begin
         sel = ((k >= 12 && k < 24) || k >= 36);
         sel_q[k] = sel;
      end
      if (k == 20 && s == 4) pd_n = 1'b0;
      if (k == 22 && s == 6) pd_n = 1'b1;
      if (k == 40 && s == 1) pd_n = 1'b0;
      if (k == 41 && s == 3) pd_n = 1'b1;
   endtask

   initial begin
      int n;
      for (int i = 0; i < 3; i++) @(negedge bclk);
      // R1: reset state
      for (int l = 0; l < NL; l++) check_bit("R1", -1, lane[l], 1'b0);
      check_bit("R1", -1, clk_lane, 1'b0);
      rst_n = 1'b1;
      for (int i = 0; i < 2; i++) @(negedge bclk);
      n = 0;
      for (int k = 0; k < NPER; k++) begin
         for (int s = 0; s < SB; s++) begin
            @(negedge bclk);
            if (k < NPER - 2) sample(n);
            n++;
            drive(k, s);
         end
      end
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(BIT_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule